// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each beat of a read or write burst in a synchronous DRAM controller. A start strobe loads a starting column along with the burst length code and ordering bit of the current mode setting. From the next cycle the block presents the first column with a valid flag. Each cycle in which the advance enable is high moves it to the next beat. A last-beat flag marks the final beat of a burst of finite length.

The columns follow one of two orderings. Sequential ordering counts up and wraps inside the aligned block of burst length. Interleaved ordering XORs the beat index into the low column bits. In full-page mode the count runs through all columns, wraps, and goes on until the burst is stopped. A terminate input stops a burst at once. A start, or a restart while busy, replaces the running burst in the same cycle. The block drives no memory pins and carries no data.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, and whenever valid_o is low, col_o is 0 and last_o is 0.
- R2: A start_i pulse without term_i makes valid_o high on the next cycle, with col_o equal to the start_col_i sampled at the pulse. This is beat 0.
- R3: With ordering bit 0 (sequential) and length codes 0,1,2,3 (lengths 1,2,4,8), beat i outputs the start column with its low log2(BL) bits replaced by (start low bits + i) mod BL. The upper bits stay fixed.
- R4: With ordering bit 1 (interleave), beat i outputs the start column with its low log2(BL) bits XORed with i.
- R5: Length code 7 with sequential ordering is full page. Beat i outputs (start + i) mod 256, wrapping from 255 to 0. The burst never ends by itself and last_o stays low.
- R6: last_o is high exactly on beat BL-1 of a finite burst. Advancing on that beat drops valid_o on the next cycle.
- R7: While valid_o is high and advance_i is low with no command, col_o, last_o and valid_o hold.
- R8: term_i drops valid_o on the next cycle. It takes priority over start_i, restart_i and advance_i in the same cycle.
- R9: start_i or restart_i during a burst restarts at beat 0 from the new start_col_i. The mode inputs are sampled again.
- R10: restart_i while idle has no effect. valid_o stays low.
- R11: Length codes 4, 5 and 6 act as length 1. Code 7 with interleave acts as length 8 interleave.
- R12: Mode inputs are sampled only at a start or restart. Changes during a burst do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bl_code_i | input | 3 | Burst length code: 0=1, 1=2, 2=4, 3=8, 7=full page |
| burst_type_i | input | 1 | Ordering: 0 sequential, 1 interleave |
| start_i | input | 1 | Begin a burst at start_col_i |
| start_col_i | input | COL_W | Starting column |
| advance_i | input | 1 | Step to the next beat |
| term_i | input | 1 | Stop the burst now |
| restart_i | input | 1 | Replace a running burst from start_col_i |
| col_o | output | COL_W | Current column |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | Current beat is the final one |

## Verification
The bench goes after the 255-to-0 wrap in full page. A design that carried into the upper bits there, or raised last_o, would leave the expected column or end the burst. Sequential bursts that start mid-block must wrap inside the block; a plain adder would instead step into the next block. Interleaved starts at odd offsets catch a design that adds where it should XOR. Terminate arriving together with start, restart while idle, and mode changes during a burst catch wrong priority and mode inputs that were not latched. Any of these would show up as a wrong valid_o or col_o.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam logic [2:0] BLC_1    = 3'd0;
  localparam logic [2:0] BLC_2    = 3'd1;
  localparam logic [2:0] BLC_4    = 3'd2;
  localparam logic [2:0] BLC_8    = 3'd3;
  localparam logic [2:0] BLC_FULL = 3'd7;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} order_e;

  typedef struct packed {
    logic [2:0] code;
    order_e     order;
  } burst_mode_t;
endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  burst_mode_t      mode_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);
  localparam int LG_W = $clog2(COL_W + 1);

  logic [LG_W-1:0] lg;

  always_comb begin
    full_o = 1'b0;
    unique case (mode_i.code)
      BLC_2:    lg = LG_W'(1);
      BLC_4:    lg = LG_W'(2);
      BLC_8:    lg = LG_W'(3);
      BLC_FULL: begin
        // interleave cannot run full page: fall back to 8
        if (mode_i.order == ORD_ILV) lg = LG_W'(3);
        else begin
          lg     = LG_W'(COL_W);
          full_o = 1'b1;
        end
      end
      default:  lg = '0;
    endcase
  end

  always_comb begin
    if (full_o) mask_o = '1;
    else        mask_o = (COL_W'(1) << lg) - COL_W'(1);
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [COL_W-1:0] beat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    beat_o <= '0;
    else if (clr_i) beat_o <= '0;
    else if (inc_i) beat_o <= beat_o + COL_W'(1);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  assign sum = base_i + beat_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? (ilv_i ? (base_i[b] ^ beat_i[b]) : sum[b])
                                : base_i[b];
  end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  burst_mode_t      mode_i,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             advance_i,
  input  logic             term_i,
  input  logic             restart_i,
  input  logic             last_i,
  output logic             valid_o,
  output logic [COL_W-1:0] base_o,
  output burst_mode_t      mode_o,
  output logic             clr_o,
  output logic             inc_o
);
  logic load, finish;

  assign load   = !term_i && (start_i || (restart_i && valid_o));
  assign finish = valid_o && advance_i && last_i;
  assign clr_o  = load || term_i;
  assign inc_o  = valid_o && advance_i && !last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      base_o  <= '0;
      mode_o  <= '0;
    end else begin
      if (term_i)      valid_o <= 1'b0;
      else if (load)   valid_o <= 1'b1;
      else if (finish) valid_o <= 1'b0;
      if (load) begin
        base_o <= start_col_i;
        mode_o <= mode_i;
      end
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       bl_code_i,
  input  logic             burst_type_i,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             advance_i,
  input  logic             term_i,
  input  logic             restart_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  burst_mode_t      mode_in, mode_q;
  logic [COL_W-1:0] base_q, beat_q, mask, col_raw;
  logic             full, clr, inc, valid_q, last_int;

  assign mode_in.code  = bl_code_i;
  assign mode_in.order = order_e'(burst_type_i);

  burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i, .rst_ni, .mode_i(mode_in), .start_i, .start_col_i,
    .advance_i, .term_i, .restart_i, .last_i(last_int),
    .valid_o(valid_q), .base_o(base_q), .mode_o(mode_q),
    .clr_o(clr), .inc_o(inc)
  );

  burst_mode_dec #(.COL_W(COL_W)) u_dec (
    .mode_i(mode_q), .mask_o(mask), .full_o(full)
  );

  burst_beat_ctr #(.COL_W(COL_W)) u_beat (
    .clk_i, .rst_ni, .clr_i(clr), .inc_i(inc), .beat_o(beat_q)
  );

  burst_col_gen #(.COL_W(COL_W)) u_gen (
    .base_i(base_q), .beat_i(beat_q), .mask_i(mask),
    .ilv_i(mode_q.order == ORD_ILV), .col_o(col_raw)
  );

  assign last_int = valid_q && !full && (beat_q == mask);
  assign last_o   = last_int;
  assign valid_o  = valid_q;
  assign col_o    = valid_q ? col_raw : '0;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       bl_code_i,
  input logic             burst_type_i,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             advance_i,
  input logic             term_i,
  input logic             restart_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  logic full_q;
  logic quiet;
  assign quiet = !term_i && !start_i && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_q <= 1'b0;
    else if (!term_i && (start_i || (restart_i && valid_o)))
      full_q <= (bl_code_i == 3'd7) && !burst_type_i;
  end

  assert_idle_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (col_o == '0) && !last_o);
  assert_start_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !term_i |=> valid_o && (col_o == $past(start_col_i)));
  assert_full_no_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && full_q |-> !last_o);
  assert_last_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
  assert_last_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && advance_i && quiet |=> !valid_o);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !advance_i && quiet |=> valid_o && $stable(col_o) && $stable(last_o));
  assert_term_kill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_i |=> !valid_o);
  assert_idle_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && restart_i && !start_i |=> !valid_o);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bl_code_i(bl_code_i),
  .burst_type_i(burst_type_i), .start_i(start_i), .start_col_i(start_col_i),
  .advance_i(advance_i), .term_i(term_i), .restart_i(restart_i),
  .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
);

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
  localparam int COL_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bl_code = '0;
  logic burst_type = 1'b0, start = 1'b0, advance = 1'b0, term = 1'b0, restart = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [COL_W-1:0] col;
  logic valid, last;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bl_code_i(bl_code), .burst_type_i(burst_type),
    .start_i(start), .start_col_i(start_col), .advance_i(advance), .term_i(term),
    .restart_i(restart), .col_o(col), .valid_o(valid), .last_o(last)
  );

  // reference model state
  bit         m_valid, m_full, m_ilv;
  int         m_base, m_beat, m_len;

  function automatic void mode_of(input int code, input bit ilv,
                                  output int len, output bit full);
    full = 0;
    case (code)
      1: len = 2;
      2: len = 4;
      3: len = 8;
      7: if (ilv) len = 8; else begin len = 256; full = 1; end
      default: len = 1;
    endcase
  endfunction

  function automatic int exp_col();
    int lo;
    if (!m_valid) return 0;
    if (m_ilv) lo = (m_base % m_len) ^ m_beat;
    else       lo = ((m_base % m_len) + m_beat) % m_len;
    return (m_base - (m_base % m_len)) + lo;
  endfunction

  function automatic bit exp_last();
    return m_valid && !m_full && (m_beat == m_len - 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    string t;
    t = tag;
    if (t == "") t = m_full ? "R5" : (m_ilv ? "R4" : "R3");
    chk(valid == m_valid, t, "valid_o", valid, m_valid);
    chk(int'(col) == exp_col(), m_valid ? t : "R1", "col_o", col, exp_col());
    chk(last == exp_last(), m_valid ? (m_full ? "R5" : "R6") : "R1", "last_o", last, exp_last());
  endtask

  // drive one cycle, advance the model, compare after the edge
  task automatic step(input bit s, input int c, input bit a, input bit t,
                      input bit r, input int code, input bit ilv, input string tag);
    bit was_last;
    start = s; start_col = COL_W'(c); advance = a; term = t; restart = r;
    bl_code = 3'(code); burst_type = ilv;
    was_last = exp_last();
    if (t) begin
      m_valid = 0;
    end else if (s || (r && m_valid)) begin
      m_valid = 1; m_base = c; m_beat = 0; m_ilv = ilv;
      mode_of(code, ilv, m_len, m_full);
    end else if (m_valid && a) begin
      if (was_last) m_valid = 0;
      else m_beat = (m_beat + 1) % 256;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    m_valid = 0; m_full = 0; m_ilv = 0; m_base = 0; m_beat = 0; m_len = 1;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R5: full page wrap 254,255,0,1 with no last
    step(1, 254, 0, 0, 0, 7, 0, "R5");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0, 1, "R5");
    chk(int'(col) == 2, "R5", "wrap col", col, 2);
    // R8: term beats start
    step(1, 9, 1, 1, 0, 3, 0, "R8");
    // R10: idle restart ignored
    step(0, 77, 1, 0, 1, 3, 0, "R10");
    step(0, 0, 1, 0, 0, 3, 0, "R10");
    // R11: code 7 interleave acts as 8 interleave: 5,4,7,6,1,0,3,2
    step(1, 8'h45, 0, 0, 0, 7, 1, "R11");
    for (int i = 0; i < 7; i++) step(0, 0, 1, 0, 0, 7, 0, "R11");
    chk(last == 1'b1 && int'(col) == 8'h42, "R11", "last beat col", col, 8'h42);
    step(0, 0, 1, 0, 0, 0, 0, "R6");
    // R11: reserved code acts as length 1
    step(1, 8'h33, 0, 0, 0, 5, 0, "R11");
    chk(last == 1'b1, "R11", "len1 last", last, 1);
    step(0, 0, 1, 0, 0, 5, 0, "R6");
    // R3 mid-block wrap: start 0x1E len 8 -> 1E,1F,18,...
    step(1, 8'h1E, 0, 0, 0, 3, 0, "R3");
    step(0, 0, 1, 0, 0, 1, 1, "R12");
    step(0, 0, 1, 0, 0, 2, 1, "R12");
    chk(int'(col) == 8'h18, "R3", "block wrap", col, 8'h18);
    // R7 hold, R9 restart mid burst
    step(0, 0, 0, 0, 0, 3, 0, "R7");
    step(0, 8'hA1, 1, 0, 1, 2, 1, "R9");
    chk(int'(col) == 8'hA1, "R9", "restart col", col, 8'hA1);
    step(0, 0, 1, 0, 0, 0, 0, "R9");
    step(1, 8'hF3, 1, 0, 0, 1, 0, "R9");
    step(0, 0, 1, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 1, 0, 0, 0, "R8");

    for (int n = 0; n < 4000; n++) begin
      int code, rv;
      rv = $urandom_range(0, 99);
      code = $urandom_range(0, 9);
      if (code > 7) code = 7;
      step(rv < 12, $urandom_range(0, 255), $urandom_range(0, 9) < 7,
           rv > 96, (rv >= 12 && rv < 17), code, $urandom_range(0, 1), "");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule